// File: doc/BRIEF.md
# Per-Register Scoreboard With Stall

This block records which architectural registers still have a result on its way to the register file in a pipelined processor. The register-read stage presents the instruction that is waiting to issue: up to two source indices, each with a flag saying whether it is read, and a destination index with a flag saying whether it is written. The block answers in the same cycle. It either issues the instruction or raises a stall because a source is still pending. When a writing instruction issues, its destination bit becomes busy from the next cycle. Writeback reports the register it has updated through a separate clear port, and that bit returns to free.

Every register has its own busy bit, so an instruction stalls only on the registers it actually reads. A set and a clear that land in the same cycle are both resolved. Set beats clear when both name the same register. An instruction that the register-read stage discards after an epoch mismatch is flagged as squashed. It leaves the vector untouched and raises neither issue nor stall. When the `BYPASS_EN` parameter is 1, a per-source bypass hit input removes that source's stall. When `BYPASS_EN` is 0, the hit inputs are ignored. The whole busy vector is visible on a query output.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset every busy bit is 0.
- R2: When an instruction with a write request and a non-zero destination issues, that destination's busy bit reads 1 from the next cycle.
- R3: A clear request for register k makes busy bit k read 0 in the next cycle, provided no issued write names k in the same cycle.
- R4: A valid, non-squashed request stalls (stall 1, issue 0) exactly when some source that is flagged as used has its busy bit set and that source is not overridden by R10. Otherwise it issues (issue 1, stall 0). A source whose used flag is 0 never causes a stall.
- R5: When an issued write and a clear name the same register in the same cycle, the register reads busy in the next cycle.
- R6: A squashed request gives issue 0 and stall 0, and it sets no busy bit.
- R7: Register 0 is never marked busy, and reading register 0 never stalls.
- R8: An issued write and a clear that name different registers in the same cycle both take effect.
- R9: A request whose write flag is 0 issues without changing any busy bit.
- R10: With BYPASS_EN=1, a bypass hit on a source cancels the stall from that source only. A stall from the other source remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | An instruction is waiting to issue |
| req_squash_i | input | 1 | Waiting instruction is discarded (epoch mismatch) |
| req_rs1_i | input | IDX_W | First source register index |
| req_rs1_used_i | input | 1 | First source is read |
| req_rs2_i | input | IDX_W | Second source register index |
| req_rs2_used_i | input | 1 | Second source is read |
| req_rd_i | input | IDX_W | Destination register index |
| req_wr_en_i | input | 1 | Instruction writes its destination |
| byp_hit1_i | input | 1 | Bypass has the value for the first source |
| byp_hit2_i | input | 1 | Bypass has the value for the second source |
| clr_valid_i | input | 1 | Writeback updated a register this cycle |
| clr_idx_i | input | IDX_W | Register updated by writeback |
| issue_o | output | 1 | Instruction issues this cycle |
| stall_o | output | 1 | Instruction must wait |
| busy_o | output | NUM_REGS | Current busy vector, bit k for register k |

## Verification
Each register in turn is marked busy and then queried on both source ports against every register index. This sweep exposes a design that decodes the wrong bit, stalls on every pending write as a global flag would, or stalls on register 0. The bench also makes a write and a clear land in the same cycle, once on the same register and once on different registers. A design with the wrong priority would leave the register free, and one that drops one of the two updates would lose a bit. Squashed requests are sent while they read busy sources and write a fresh register. A design that handles this wrongly leaks a busy bit or raises a stall. Bypass hits are tried one source at a time, which catches a hit that wrongly cancels the other source's stall.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [1:0] {
    SRC_UNUSED = 2'd0,
    SRC_READY  = 2'd1,
    SRC_BYPASS = 2'd2,
    SRC_WAIT   = 2'd3
  } src_verdict_e;
endpackage

// File: rtl/scb_src_check.sv
module scb_src_check
  import scb_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int IDX_W     = $clog2(NUM_REGS),
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic [NUM_REGS-1:0] busy_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                used_i,
  input  logic                byp_hit_i,
  output src_verdict_e        verdict_o,
  output logic                hazard_o
);
  logic pending;
  logic hit;

  // register 0 is hardwired free
  assign pending = used_i && (idx_i != '0) && busy_i[idx_i];

  generate
    if (BYPASS_EN) begin : g_byp
      assign hit = byp_hit_i;
    end else begin : g_nobyp
      logic unused_hit;
      assign unused_hit = byp_hit_i;
      assign hit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!used_i)            verdict_o = SRC_UNUSED;
    else if (!pending)      verdict_o = SRC_READY;
    else if (hit)           verdict_o = SRC_BYPASS;
    else                    verdict_o = SRC_WAIT;
  end

  assign hazard_o = (verdict_o == SRC_WAIT);
endmodule

// File: rtl/scb_next.sv
module scb_next #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] busy_q_i,
  input  logic                set_en_i,
  input  logic [IDX_W-1:0]    set_idx_i,
  input  logic                clr_en_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  output logic [NUM_REGS-1:0] busy_d_o
);
  assign busy_d_o[0] = 1'b0;

  genvar k;
  generate
    for (k = 1; k < NUM_REGS; k++) begin : g_bit
      logic set_hit, clr_hit;
      assign set_hit = set_en_i && (set_idx_i == IDX_W'(k));
      assign clr_hit = clr_en_i && (clr_idx_i == IDX_W'(k));
      // set wins over clear on the same entry
      assign busy_d_o[k] = set_hit || (busy_q_i[k] && !clr_hit);
    end
  endgenerate
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
  import scb_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int IDX_W     = $clog2(NUM_REGS),
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_squash_i,
  input  logic [IDX_W-1:0]    req_rs1_i,
  input  logic                req_rs1_used_i,
  input  logic [IDX_W-1:0]    req_rs2_i,
  input  logic                req_rs2_used_i,
  input  logic [IDX_W-1:0]    req_rd_i,
  input  logic                req_wr_en_i,
  input  logic                byp_hit1_i,
  input  logic                byp_hit2_i,
  input  logic                clr_valid_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  output logic                issue_o,
  output logic                stall_o,
  output logic [NUM_REGS-1:0] busy_o
);
  localparam int NUM_SRC = 2;

  logic [NUM_REGS-1:0] busy_q, busy_d;
  logic [NUM_SRC-1:0][IDX_W-1:0] src_idx;
  logic [NUM_SRC-1:0] src_used, src_hit, src_hazard;
  src_verdict_e [NUM_SRC-1:0] src_verdict;
  logic live, any_hazard, set_en;

  assign src_idx  = {req_rs2_i, req_rs1_i};
  assign src_used = {req_rs2_used_i, req_rs1_used_i};
  assign src_hit  = {byp_hit2_i, byp_hit1_i};

  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_src
      scb_src_check #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .BYPASS_EN(BYPASS_EN)
      ) i_src_check (
        .busy_i   (busy_q),
        .idx_i    (src_idx[s]),
        .used_i   (src_used[s]),
        .byp_hit_i(src_hit[s]),
        .verdict_o(src_verdict[s]),
        .hazard_o (src_hazard[s])
      );
    end
  endgenerate

  assign live       = req_valid_i && !req_squash_i;
  assign any_hazard = |src_hazard;
  assign stall_o    = live && any_hazard;
  assign issue_o    = live && !any_hazard;
  assign set_en     = issue_o && req_wr_en_i;

  scb_next #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) i_next (
    .busy_q_i (busy_q),
    .set_en_i (set_en),
    .set_idx_i(req_rd_i),
    .clr_en_i (clr_valid_i),
    .clr_idx_i(clr_idx_i),
    .busy_d_o (busy_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_d;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int NUM_REGS  = 32,
  parameter int IDX_W     = $clog2(NUM_REGS),
  parameter bit BYPASS_EN = 1'b1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_squash_i,
  input logic [IDX_W-1:0]    req_rs1_i,
  input logic                req_rs1_used_i,
  input logic [IDX_W-1:0]    req_rd_i,
  input logic                req_wr_en_i,
  input logic                byp_hit1_i,
  input logic                clr_valid_i,
  input logic [IDX_W-1:0]    clr_idx_i,
  input logic                issue_o,
  input logic                stall_o,
  input logic [NUM_REGS-1:0] busy_o
);
  logic [IDX_W-1:0] rd_q, clr_q;
  logic set_q, clr_only_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0; clr_q <= '0; set_q <= 1'b0; clr_only_q <= 1'b0;
    end else begin
      rd_q       <= req_rd_i;
      clr_q      <= clr_idx_i;
      set_q      <= issue_o && req_wr_en_i && (req_rd_i != '0);
      clr_only_q <= clr_valid_i &&
                    !(issue_o && req_wr_en_i && req_rd_i == clr_idx_i);
    end
  end

  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue_o && stall_o));

  a_r7_zero_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o[0]);

  a_r2_set_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_q |-> busy_o[rd_q]);

  a_r3_clear_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_only_q |-> !busy_o[clr_q]);

  a_r6_squash_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_squash_i && !clr_valid_i) |=> (busy_o == $past(busy_o)));

  a_r6_squash_no_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_squash_i |-> (!issue_o && !stall_o));

  a_r4_stall_on_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_squash_i && req_rs1_used_i && req_rs1_i != '0 &&
     busy_o[req_rs1_i] && !(BYPASS_EN && byp_hit1_i)) |-> stall_o);
endmodule

bind reg_scoreboard scb_checker #(
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W),
  .BYPASS_EN(BYPASS_EN)
) i_scb_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_squash_i  (req_squash_i),
  .req_rs1_i     (req_rs1_i),
  .req_rs1_used_i(req_rs1_used_i),
  .req_rd_i      (req_rd_i),
  .req_wr_en_i   (req_wr_en_i),
  .byp_hit1_i    (byp_hit1_i),
  .clr_valid_i   (clr_valid_i),
  .clr_idx_i     (clr_idx_i),
  .issue_o       (issue_o),
  .stall_o       (stall_o),
  .busy_o        (busy_o)
);

// File: tb/test_reg_scoreboard.sv
`timescale 1ns/1ps
module test_reg_scoreboard;
  localparam int NUM_REGS = 32;
  localparam int IDX_W    = 5;
  localparam bit BYP      = 1'b1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_squash_i = 0, req_rs1_used_i = 0, req_rs2_used_i = 0;
  logic req_wr_en_i = 0, byp_hit1_i = 0, byp_hit2_i = 0, clr_valid_i = 0;
  logic [IDX_W-1:0] req_rs1_i = 0, req_rs2_i = 0, req_rd_i = 0, clr_idx_i = 0;
  logic issue_o, stall_o;
  logic [NUM_REGS-1:0] busy_o;

  int n_chk = 0, n_fail = 0;
  logic [NUM_REGS-1:0] model = '0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  reg_scoreboard #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .BYPASS_EN(BYP)) i_reg_scoreboard (
    .clk_i, .rst_ni, .req_valid_i, .req_squash_i, .req_rs1_i, .req_rs1_used_i,
    .req_rs2_i, .req_rs2_used_i, .req_rd_i, .req_wr_en_i, .byp_hit1_i, .byp_hit2_i,
    .clr_valid_i, .clr_idx_i, .issue_o, .stall_o, .busy_o);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid_i = 0; req_squash_i = 0; req_rs1_used_i = 0; req_rs2_used_i = 0;
    req_wr_en_i = 0; byp_hit1_i = 0; byp_hit2_i = 0; clr_valid_i = 0;
    req_rs1_i = 0; req_rs2_i = 0; req_rd_i = 0; clr_idx_i = 0;
  endtask

  // inputs already driven after a negedge; check outputs, advance one cycle, check vector
  task automatic cycle(input string tag);
    logic h1, h2, e_stall, e_issue, live;
    #2;
    live = req_valid_i && !req_squash_i;
    h1 = req_rs1_used_i && req_rs1_i != 0 && model[req_rs1_i] && !(BYP && byp_hit1_i);
    h2 = req_rs2_used_i && req_rs2_i != 0 && model[req_rs2_i] && !(BYP && byp_hit2_i);
    e_stall = live && (h1 || h2);
    e_issue = live && !(h1 || h2);
    chk({tag, " stall"}, 64'(stall_o), 64'(e_stall));
    chk({tag, " issue"}, 64'(issue_o), 64'(e_issue));
    if (clr_valid_i) model[clr_idx_i] = 1'b0;
    if (e_issue && req_wr_en_i && req_rd_i != 0) model[req_rd_i] = 1'b1;
    @(negedge clk_i);
    chk({tag, " busy"}, 64'(busy_o), 64'(model));
    idle();
  endtask

  task automatic do_write(input int rd, input string tag);
    req_valid_i = 1; req_wr_en_i = 1; req_rd_i = IDX_W'(rd);
    cycle(tag);
  endtask

  task automatic do_clear(input int r, input string tag);
    clr_valid_i = 1; clr_idx_i = IDX_W'(r);
    cycle(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset vector", 64'(busy_o), 64'(0));

    // sweep: mark a, query every b on each source, then clear
    for (int a = 1; a < NUM_REGS; a++) begin
      do_write(a, "R2 mark");
      for (int b = 0; b < NUM_REGS; b++) begin
        req_valid_i = 1; req_rs1_used_i = 1; req_rs1_i = IDX_W'(b);
        cycle("R4 src1 query R9");
        req_valid_i = 1; req_rs2_used_i = 1; req_rs2_i = IDX_W'(b);
        cycle("R4 src2 query R7");
      end
      req_valid_i = 1; req_rs1_i = IDX_W'(a); req_rs2_i = IDX_W'(a);
      cycle("R4 unused sources");
      do_clear(a, "R3 clear");
    end

    // register 0
    do_write(0, "R7 write r0");
    req_valid_i = 1; req_rs1_used_i = 1; req_rs2_used_i = 1;
    cycle("R7 read r0");

    // same-register set and clear
    req_valid_i = 1; req_wr_en_i = 1; req_rd_i = 7; clr_valid_i = 1; clr_idx_i = 7;
    cycle("R5 set+clear free reg");
    req_valid_i = 1; req_wr_en_i = 1; req_rd_i = 7; clr_valid_i = 1; clr_idx_i = 7;
    cycle("R5 set+clear busy reg");
    do_clear(7, "R3 clear r7");

    // different registers
    do_write(3, "R2 mark r3");
    req_valid_i = 1; req_wr_en_i = 1; req_rd_i = 4; clr_valid_i = 1; clr_idx_i = 3;
    cycle("R8 set r4 clear r3");
    do_write(20, "R2 mark r20");
    req_valid_i = 1; req_wr_en_i = 1; req_rd_i = 21; clr_valid_i = 1; clr_idx_i = 4;
    cycle("R8 set r21 clear r4");

    // squash while reading busy sources and writing a fresh reg
    req_valid_i = 1; req_squash_i = 1; req_rs1_used_i = 1; req_rs1_i = 20;
    req_wr_en_i = 1; req_rd_i = 9;
    cycle("R6 squash busy src");
    req_valid_i = 1; req_squash_i = 1; req_wr_en_i = 1; req_rd_i = 10;
    cycle("R6 squash free");

    // no-write instruction leaves vector
    req_valid_i = 1; req_rs1_used_i = 1; req_rs1_i = 5; req_rd_i = 12;
    cycle("R9 no write");

    // bypass overrides
    req_valid_i = 1; req_rs1_used_i = 1; req_rs1_i = 20; byp_hit1_i = 1;
    cycle("R10 hit1 on busy src1");
    req_valid_i = 1; req_rs1_used_i = 1; req_rs1_i = 20; byp_hit2_i = 1;
    cycle("R10 hit2 wrong source");
    req_valid_i = 1; req_rs1_used_i = 1; req_rs1_i = 20; req_rs2_used_i = 1;
    req_rs2_i = 21; byp_hit1_i = 1;
    cycle("R10 other source still busy");
    req_valid_i = 1; req_rs1_used_i = 1; req_rs1_i = 20; req_rs2_used_i = 1;
    req_rs2_i = 21; byp_hit1_i = 1; byp_hit2_i = 1; req_wr_en_i = 1; req_rd_i = 22;
    cycle("R10 both hits issue R2");

    do_clear(20, "R3 clear r20");
    do_clear(21, "R3 clear r21");
    do_clear(22, "R3 clear r22");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule